// File: doc/BRIEF.md
# Serial Console Output Device

This block is the transmit half of a console serial port that sits on a 12-bit programmed-I/O bus. The processor issues an I/O transfer by pulsing a strobe together with a 6-bit device code, a 3-bit command and the 12-bit accumulator value. When the device code matches this unit's code, the command is decoded. Depending on the command, the unit tests or changes its ready flag, answers with a skip, loads a baud-rate index, or hands the low eight accumulator bits to a UART transmitter over a valid/ready handshake.

The ready flag ("done") tells software that another character may be written. It is set out of reset. A completion pulse from the transmitter sets it again, and commands can set or clear it directly. One skip command also looks at the ready flag of the paired keyboard receiver, so a console poll loop can wait on either side with a single instruction. When the flag is set and the external interrupt enable is high, an interrupt request is raised. The serial shifter and the bit-rate divider sit outside this block, and it only presents the selected 4-bit rate index to them.

Top module: `con_out_iot`

## Requirements
- R1: After synchronous reset the done flag is set, `baud_sel` is 14 (the 9600 bps index), `tx_valid` is 0 and `tx_data` is 0.
- R2: A strobe takes effect only when `io_dev` equals parameter `DEV_CODE` (default octal 31). A strobe with any other code gives `io_skip` = 0 and changes no state.
- R3: `io_skip` is combinational in the strobe cycle. Command 1 gives the done flag. Command 5 gives done OR `rx_flag_in`. Every other command gives 0.
- R4: Command 0 sets the done flag and command 2 clears it, both effective from the next cycle.
- R5: Commands 4 and 6 capture `io_ac[7:0]` when no character is held, and `tx_valid` is high with that data from the next cycle. Command 6 also clears the done flag. Command 4 leaves the flag unchanged.
- R6: A held character keeps `tx_valid` high with stable `tx_data` until a cycle with `tx_ready` high, and `tx_valid` is low in the cycle after that handshake.
- R7: A print command (4 or 6) issued while `tx_valid` is high is dropped and the held data does not change. The flag-clear of command 6 still applies.
- R8: A one-cycle `tx_done` pulse sets the done flag from the next cycle. This set wins over a clear command (2 or 6) in the same cycle.
- R9: Command 3 loads `io_ac[3:0]` into `baud_sel` from the next cycle.
- R10: `irq` equals done AND `int_en`, combinationally.
- R11: Command 7 changes no state and gives no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | I/O transfer strobe, one cycle per instruction |
| io_dev | input | 6 | Device code of the transfer |
| io_cmd | input | 3 | Command code of the transfer |
| io_ac | input | 12 | Accumulator value supplied with the transfer |
| io_skip | output | 1 | Skip answer for the current transfer |
| rx_flag_in | input | 1 | Ready flag of the paired receiver |
| int_en | input | 1 | Output interrupt enable |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Character held for the transmitter |
| tx_data | output | 8 | Held character |
| tx_ready | input | 1 | Transmitter accepts the held character |
| tx_done | input | 1 | Transmitter finished a character (one-cycle pulse) |
| baud_sel | output | 4 | Selected bit-rate index |

## Verification
`io_skip` and `irq` are combinational, so they are due in the same cycle as the strobe or the input that causes them. Flag changes, the baud index and the held character appear one register later, in the cycle after the strobe. A handshake drops `tx_valid` one cycle after `tx_ready` is seen. The bench drives all inputs just after the falling edge and compares a behavioural model one nanosecond later. At that point the same-cycle combinational answers have settled, and every registered output shows the result of the preceding rising edge. The model's state is advanced only after that comparison, which matches the one-register delay.

// File: rtl/cout_pkg.sv
package cout_pkg;

    localparam int AC_W   = 12;
    localparam int DEV_W  = 6;
    localparam int CMD_W  = 3;
    localparam int CHAR_W = 8;
    localparam int RATE_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_SET_FLAG  = 3'd0,
        CMD_SKIP_FLAG = 3'd1,
        CMD_CLR_FLAG  = 3'd2,
        CMD_LOAD_RATE = 3'd3,
        CMD_PRINT     = 3'd4,
        CMD_SKIP_ANY  = 3'd5,
        CMD_PRINT_CLR = 3'd6,
        CMD_IDLE      = 3'd7
    } cmd_e;

    typedef struct packed {
        logic set_flag;
        logic clr_flag;
        logic print;
        logic load_rate;
        logic skip_flag;
        logic skip_any;
    } act_t;

    function automatic act_t decode_cmd(input logic hit, input logic [CMD_W-1:0] code);
        act_t a;
        a = '0;
        if (hit) begin
            case (cmd_e'(code))
                CMD_SET_FLAG:  a.set_flag  = 1'b1;
                CMD_SKIP_FLAG: a.skip_flag = 1'b1;
                CMD_CLR_FLAG:  a.clr_flag  = 1'b1;
                CMD_LOAD_RATE: a.load_rate = 1'b1;
                CMD_PRINT:     a.print     = 1'b1;
                CMD_SKIP_ANY:  a.skip_any  = 1'b1;
                CMD_PRINT_CLR: begin
                    a.print    = 1'b1;
                    a.clr_flag = 1'b1;
                end
                default: a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/cout_decode.sv
module cout_decode
    import cout_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_CODE = 6'o31
) (
    input  logic             strobe,
    input  logic [DEV_W-1:0] dev,
    input  logic [CMD_W-1:0] cmd,
    output logic             set_flag,
    output logic             clr_flag,
    output logic             print,
    output logic             load_rate,
    output logic             skip_flag,
    output logic             skip_any
);
    act_t act;
    logic hit;

    always_comb begin
        hit       = strobe && (dev == DEV_CODE);
        act       = decode_cmd(hit, cmd);
        set_flag  = act.set_flag;
        clr_flag  = act.clr_flag;
        print     = act.print;
        load_rate = act.load_rate;
        skip_flag = act.skip_flag;
        skip_any  = act.skip_any;
    end
endmodule

// File: rtl/cout_flag.sv
module cout_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_flag,
    input  logic clr_flag,
    input  logic tx_done,
    input  logic skip_flag,
    input  logic skip_any,
    input  logic rx_flag,
    input  logic int_en,
    output logic done_q,
    output logic skip,
    output logic irq
);
    logic set_any;

    always_comb begin
        set_any = set_flag || tx_done;
        skip    = (skip_flag && done_q) || (skip_any && (done_q || rx_flag));
        irq     = done_q && int_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b1;
        end else if (set_any) begin
            done_q <= 1'b1;
        end else if (clr_flag) begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cout_hold.sv
module cout_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         print,
    input  logic [W-1:0] char_in,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] ch;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.full) begin
            if (ready) slot_d.full = 1'b0;
        end else if (print) begin
            slot_d.full = 1'b1;
            slot_d.ch   = char_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign valid = slot_q.full;
    assign data  = slot_q.ch;
endmodule

// File: rtl/cout_rate.sv
module cout_rate #(
    parameter int          W     = 4,
    parameter logic [W-1:0] RESET = 4'd14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic [W-1:0] rate
);
    always_ff @(posedge clk) begin
        if (rst)       rate <= RESET;
        else if (load) rate <= value;
    end
endmodule

// File: rtl/con_out_iot.sv
module con_out_iot
    import cout_pkg::*;
#(
    parameter logic [DEV_W-1:0]  DEV_CODE   = 6'o31,
    parameter logic [RATE_W-1:0] RATE_RESET = 4'd14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_strobe,
    input  logic [DEV_W-1:0]  io_dev,
    input  logic [CMD_W-1:0]  io_cmd,
    input  logic [AC_W-1:0]   io_ac,
    output logic              io_skip,
    input  logic              rx_flag_in,
    input  logic              int_en,
    output logic              irq,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic [RATE_W-1:0] baud_sel
);
    logic set_flag, clr_flag, print, load_rate, skip_flag, skip_any;
    logic done_q;
    logic ac_hi_unused;

    assign ac_hi_unused = ^io_ac[AC_W-1:CHAR_W];

    cout_decode #(.DEV_CODE(DEV_CODE)) u_decode (
        .strobe    (io_strobe),
        .dev       (io_dev),
        .cmd       (io_cmd),
        .set_flag  (set_flag),
        .clr_flag  (clr_flag),
        .print     (print),
        .load_rate (load_rate),
        .skip_flag (skip_flag),
        .skip_any  (skip_any)
    );

    cout_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .set_flag  (set_flag),
        .clr_flag  (clr_flag),
        .tx_done   (tx_done),
        .skip_flag (skip_flag),
        .skip_any  (skip_any),
        .rx_flag   (rx_flag_in),
        .int_en    (int_en),
        .done_q    (done_q),
        .skip      (io_skip),
        .irq       (irq)
    );

    cout_hold #(.W(CHAR_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .print   (print),
        .char_in (io_ac[CHAR_W-1:0]),
        .ready   (tx_ready),
        .valid   (tx_valid),
        .data    (tx_data)
    );

    cout_rate #(.W(RATE_W), .RESET(RATE_RESET)) u_rate (
        .clk   (clk),
        .rst   (rst),
        .load  (load_rate),
        .value (io_ac[RATE_W-1:0]),
        .rate  (baud_sel)
    );
endmodule

// File: rtl/cout_checker.sv
module cout_checker
    import cout_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_CODE = 6'o31
) (
    input logic              clk,
    input logic              rst,
    input logic              io_strobe,
    input logic [DEV_W-1:0]  io_dev,
    input logic [CMD_W-1:0]  io_cmd,
    input logic [AC_W-1:0]   io_ac,
    input logic              io_skip,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [CHAR_W-1:0] tx_data,
    input logic              tx_done,
    input logic              done_q,
    input logic [RATE_W-1:0] baud_sel
);
    logic hit;
    assign hit = io_strobe && (io_dev == DEV_CODE);

    p_foreign_noskip_r2: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && io_dev != DEV_CODE) |-> !io_skip);

    p_skip_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && io_cmd == 3'd1) |-> (io_skip == done_q));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && io_cmd == 3'd2 && !tx_done) |=> !done_q);

    p_print_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && (io_cmd == 3'd4 || io_cmd == 3'd6) && !tx_valid)
        |=> (tx_valid && tx_data == $past(io_ac[CHAR_W-1:0])));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);

    p_done_sets_r8: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> done_q);

    p_rate_load_r9: assert property (@(posedge clk) disable iff (rst)
        (hit && io_cmd == 3'd3) |=> (baud_sel == $past(io_ac[RATE_W-1:0])));
endmodule

bind con_out_iot cout_checker #(.DEV_CODE(DEV_CODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_strobe (io_strobe),
    .io_dev    (io_dev),
    .io_cmd    (io_cmd),
    .io_ac     (io_ac),
    .io_skip   (io_skip),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_done   (tx_done),
    .done_q    (done_q),
    .baud_sel  (baud_sel)
);

// File: tb/con_out_iot_bench.sv
`timescale 1ns/1ps
module con_out_iot_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_strobe = 1'b0;
    logic [5:0]  io_dev = '0;
    logic [2:0]  io_cmd = '0;
    logic [11:0] io_ac = '0;
    logic        rx_flag_in = 1'b0;
    logic        int_en = 1'b0;
    logic        tx_ready = 1'b0;
    logic        tx_done = 1'b0;
    logic        io_skip, irq, tx_valid;
    logic [7:0]  tx_data;
    logic [3:0]  baud_sel;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    bit       m_done;
    bit       m_full;
    bit [7:0] m_ch;
    bit [3:0] m_rate;

    always #2.5 clk = ~clk;

    con_out_iot u_con_out_iot (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_dev(io_dev),
        .io_cmd(io_cmd), .io_ac(io_ac), .io_skip(io_skip),
        .rx_flag_in(rx_flag_in), .int_en(int_en), .irq(irq),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_done(tx_done), .baud_sel(baud_sel)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: inputs are already driven just after a falling edge.
    task automatic step(input bit stb, input bit [5:0] dev, input bit [2:0] cmd,
                        input bit [11:0] ac, input bit rx, input bit ie,
                        input bit rdy, input bit dn);
        bit hit, e_skip;
        io_strobe = stb; io_dev = dev; io_cmd = cmd; io_ac = ac;
        rx_flag_in = rx; int_en = ie; tx_ready = rdy; tx_done = dn;
        #1;
        hit    = stb && dev == 6'o31;
        e_skip = hit && ((cmd == 3'd1 && m_done) || (cmd == 3'd5 && (m_done || rx)));
        check("R3", "io_skip", io_skip, e_skip);
        check("R10", "irq", irq, m_done && ie);
        check("R5", "tx_valid", tx_valid, m_full);
        check("R6", "tx_data", tx_data, m_ch);
        check("R9", "baud_sel", baud_sel, m_rate);
        // advance model
        if (dn || (hit && cmd == 3'd0))            m_done = 1'b1;
        else if (hit && (cmd == 3'd2 || cmd == 3'd6)) m_done = 1'b0;
        if (m_full) begin
            if (rdy) m_full = 1'b0;
        end else if (hit && (cmd == 3'd4 || cmd == 3'd6)) begin
            m_full = 1'b1;
            m_ch   = ac[7:0];
        end
        if (hit && cmd == 3'd3) m_rate = ac[3:0];
        @(negedge clk);
    endtask

    task automatic iot(input bit [2:0] cmd, input bit [11:0] ac);
        step(1'b1, 6'o31, cmd, ac, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_done = 1'b1; m_full = 1'b0; m_ch = 8'h00; m_rate = 4'd14;
        #1;
        // R1: reset state
        check("R1", "baud_sel reset", baud_sel, 14);
        check("R1", "tx_valid reset", tx_valid, 0);
        check("R1", "tx_data reset", tx_data, 0);
        @(negedge clk);
        // R1/R3: flag set after reset, skip on command 1
        iot(3'd1, 12'h0);
        // R4: clear then test, set then test
        iot(3'd2, 12'h0);
        iot(3'd1, 12'h0);
        // R3: command 5 with receiver flag low and high
        step(1'b1, 6'o31, 3'd5, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 6'o31, 3'd5, 12'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        iot(3'd0, 12'h0);
        iot(3'd1, 12'h0);
        // R2: foreign device codes do nothing
        step(1'b1, 6'o30, 3'd2, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 6'o30, 3'd1, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 6'o13, 3'd3, 12'h7, 1'b0, 1'b0, 1'b0, 1'b0);
        iot(3'd1, 12'h0);
        // R9: rate load
        iot(3'd3, 12'hF25);
        idle();
        // R5: command 4 keeps flag, then R6 hold while not ready
        iot(3'd4, 12'h141);
        idle();
        idle();
        iot(3'd1, 12'h0);
        // R7: print while holding is dropped, clear of command 6 applies
        iot(3'd6, 12'h055);
        iot(3'd1, 12'h0);
        // R6: handshake releases
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        idle();
        // R8: completion sets flag; set wins over same-cycle clear
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        iot(3'd1, 12'h0);
        step(1'b1, 6'o31, 3'd2, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        iot(3'd1, 12'h0);
        // R5: command 6 with ready already high
        step(1'b1, 6'o31, 3'd6, 12'h0AA, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        iot(3'd1, 12'h0);
        // R11: command 7 is inert
        iot(3'd7, 12'hFFF);
        iot(3'd1, 12'h0);
        // R10: interrupt follows flag and enable
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 6'o31, 3'd2, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 6'o31, 3'd0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        // mixed random traffic, model compared every cycle
        for (int i = 0; i < 600; i++) begin
            bit [5:0] d;
            d = ($urandom_range(0, 3) != 0) ? 6'o31 : 6'($urandom_range(0, 63));
            step(1'($urandom_range(0, 1)), d, 3'($urandom_range(0, 7)),
                 12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 7) == 0));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule